// File: doc/BRIEF.md
# Z80 Bus Memory and Port Decoder

This block is the combinational glue that sits between a Z80-style processor with a 16-bit address bus and its memories and expansion slots. It watches the active-low bus strobes (memory request, I/O request, read, write, opcode fetch) and the address. From them it produces chip enables, output enables and a write enable for one ROM and one RAM. It also produces eight active-low device selects for the expansion slots.

Memory is split into two regions. The bottom 8K of the address space belongs to the ROM. The ROM device is larger than that window, so static switch inputs choose which 8K bank appears there and drive the ROM's upper address lines. The remaining 56K belongs to the RAM, whose address lines above the 64K processor space are tied to a constant.

Port space is split into eight equal 32-port windows, one per device. Bits 7..5 of the port address pick the device, and bits 4..0 are handed on unchanged so that a card can decode further. An interrupt acknowledge (I/O request together with opcode fetch) selects no device.

Top module: `z80_bus_decoder`

## Requirements
- R1: `romCeN` is low exactly when `mreqN` is low and the address is below 0x2000.
- R2: `ramCeN` is low exactly when `mreqN` is low and the address is 0x2000 or above.
- R3: `romCeN` and `ramCeN` are never low together, and both are high while `mreqN` is high.
- R4: While `iorqN` is low and `m1N` is high, exactly one bit of `ioSelN` is low: bit number addr[7:5] (bit 0 for ports 0x00–0x1F, bit 7 for ports 0xE0–0xFF).
- R5: While `iorqN` is high, all eight bits of `ioSelN` are high.
- R6: While `iorqN` and `m1N` are both low (interrupt acknowledge), all bits of `ioSelN` are high.
- R7: `ioOffset` always equals addr[4:0].
- R8: `romHiAddr` always equals `romBank`.
- R9: `ramHiAddr` is always the constant parameter value, zero by default.
- R10: `romOeN` is low exactly when `romCeN` and `rdN` are both low. `ramOeN` is low exactly when `ramCeN` and `rdN` are both low.
- R11: `ramWeN` is low exactly when `ramCeN` and `wrN` are both low. A write into the ROM window drives no write strobe and no output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | Processor address bus |
| mreqN | input | 1 | Memory request, active low |
| iorqN | input | 1 | I/O request, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| m1N | input | 1 | Opcode fetch cycle, active low |
| romBank | input | 3 | Static ROM bank number from switches |
| romCeN | output | 1 | ROM chip enable, active low |
| ramCeN | output | 1 | RAM chip enable, active low |
| romOeN | output | 1 | ROM output enable, active low |
| ramOeN | output | 1 | RAM output enable, active low |
| ramWeN | output | 1 | RAM write enable, active low |
| romHiAddr | output | 3 | ROM address lines above the 8K window |
| ramHiAddr | output | 3 | RAM address lines above 64K |
| ioSelN | output | 8 | Device selects, one per 32-port window, active low |
| ioOffset | output | 5 | Port offset within a device window |

## Verification
The bench builds the decoder with its default parameters: a 16-bit bus, a 13-bit ROM window, three bank bits and three device-number bits. At these sizes the port space is small enough to sweep all 256 port numbers, both with the I/O request active and with it idle. Every one of the eight bank settings can also be run against both sides of the ROM/RAM boundary at 0x1FFF and 0x2000, for reads and for writes. Interrupt-acknowledge cycles and a run of random bus states cover the exclusivity and strobe-gating rules.

// File: rtl/z80_decode_pkg.sv
package z80_decode_pkg;
  // Strobes from the control decode to the output datapath
  typedef struct packed {
    logic romHit;
    logic ramHit;
    logic ioHit;
    logic rdStb;
    logic wrStb;
  } busStrobe_t;
endpackage

// File: rtl/bus_decode_ctrl.sv
module bus_decode_ctrl
  import z80_decode_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int ROM_WIN_BITS = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreqN,
  input  logic              iorqN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              m1N,
  output busStrobe_t        stb
);
  localparam int REGION_W = ADDR_W - ROM_WIN_BITS;

  logic romRegion;
  logic memCycle;
  logic ioCycle;

  always_comb begin
    romRegion = (addr[ADDR_W-1:ROM_WIN_BITS] == REGION_W'(0));
    memCycle  = !mreqN;
    // opcode fetch with I/O request is an interrupt acknowledge
    ioCycle   = !iorqN && m1N;
    stb.romHit = memCycle && romRegion;
    stb.ramHit = memCycle && !romRegion;
    stb.ioHit  = ioCycle;
    stb.rdStb  = !rdN;
    stb.wrStb  = !wrN;
  end
endmodule

// File: rtl/bus_decode_path.sv
module bus_decode_path
  import z80_decode_pkg::*;
#(
  parameter int IO_PORT_W   = 8,
  parameter int IO_SEL_W    = 3,
  parameter int ROM_BANK_W  = 3,
  parameter int RAM_UPPER_W = 3,
  parameter logic [RAM_UPPER_W-1:0] RAM_UPPER_VAL = '0,
  localparam int NUM_IO     = 1 << IO_SEL_W,
  localparam int OFFSET_W   = IO_PORT_W - IO_SEL_W
) (
  input  busStrobe_t             stb,
  input  logic [IO_PORT_W-1:0]   portAddr,
  input  logic [ROM_BANK_W-1:0]  romBank,
  output logic                   romCeN,
  output logic                   ramCeN,
  output logic                   romOeN,
  output logic                   ramOeN,
  output logic                   ramWeN,
  output logic [ROM_BANK_W-1:0]  romHiAddr,
  output logic [RAM_UPPER_W-1:0] ramHiAddr,
  output logic [NUM_IO-1:0]      ioSelN,
  output logic [OFFSET_W-1:0]    ioOffset
);
  logic [IO_SEL_W-1:0] devIdx;

  assign devIdx   = portAddr[IO_PORT_W-1 -: IO_SEL_W];
  assign ioOffset = portAddr[OFFSET_W-1:0];

  always_comb begin
    romCeN    = !stb.romHit;
    ramCeN    = !stb.ramHit;
    romOeN    = !(stb.romHit && stb.rdStb);
    ramOeN    = !(stb.ramHit && stb.rdStb);
    // the ROM has no write path: writes there drop silently
    ramWeN    = !(stb.ramHit && stb.wrStb);
    romHiAddr = romBank;
    ramHiAddr = RAM_UPPER_VAL;
  end

  for (genvar i = 0; i < NUM_IO; i++) begin : g_ioSel
    assign ioSelN[i] = !(stb.ioHit && (devIdx == IO_SEL_W'(i)));
  end

  always_comb begin
    assert_io_onehot_R4: assert ($onehot0(~ioSelN))
      else $error("more than one device select active");
  end
endmodule

// File: rtl/z80_bus_decoder.sv
module z80_bus_decoder
  import z80_decode_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int ROM_WIN_BITS = 13,
  parameter int ROM_BANK_W   = 3,
  parameter int RAM_UPPER_W  = 3,
  parameter int IO_PORT_W    = 8,
  parameter int IO_SEL_W     = 3,
  localparam int NUM_IO      = 1 << IO_SEL_W,
  localparam int OFFSET_W    = IO_PORT_W - IO_SEL_W
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   mreqN,
  input  logic                   iorqN,
  input  logic                   rdN,
  input  logic                   wrN,
  input  logic                   m1N,
  input  logic [ROM_BANK_W-1:0]  romBank,
  output logic                   romCeN,
  output logic                   ramCeN,
  output logic                   romOeN,
  output logic                   ramOeN,
  output logic                   ramWeN,
  output logic [ROM_BANK_W-1:0]  romHiAddr,
  output logic [RAM_UPPER_W-1:0] ramHiAddr,
  output logic [NUM_IO-1:0]      ioSelN,
  output logic [OFFSET_W-1:0]    ioOffset
);
  busStrobe_t stb;

  bus_decode_ctrl #(
    .ADDR_W      (ADDR_W),
    .ROM_WIN_BITS(ROM_WIN_BITS)
  ) u_ctrl (
    .addr (addr),
    .mreqN(mreqN),
    .iorqN(iorqN),
    .rdN  (rdN),
    .wrN  (wrN),
    .m1N  (m1N),
    .stb  (stb)
  );

  bus_decode_path #(
    .IO_PORT_W    (IO_PORT_W),
    .IO_SEL_W     (IO_SEL_W),
    .ROM_BANK_W   (ROM_BANK_W),
    .RAM_UPPER_W  (RAM_UPPER_W),
    .RAM_UPPER_VAL('0)
  ) u_path (
    .stb      (stb),
    .portAddr (addr[IO_PORT_W-1:0]),
    .romBank  (romBank),
    .romCeN   (romCeN),
    .ramCeN   (ramCeN),
    .romOeN   (romOeN),
    .ramOeN   (ramOeN),
    .ramWeN   (ramWeN),
    .romHiAddr(romHiAddr),
    .ramHiAddr(ramHiAddr),
    .ioSelN   (ioSelN),
    .ioOffset (ioOffset)
  );

  // port-level invariants across the two sub-blocks
  always_comb begin
    assert_ce_exclusive_R3: assert (romCeN || ramCeN)
      else $error("ROM and RAM enabled together");
    assert_mem_idle_R3: assert (!mreqN || (romCeN && ramCeN))
      else $error("memory enable without memory request");
    assert_io_idle_R5: assert (!iorqN || (&ioSelN))
      else $error("device select without I/O request");
    assert_inta_quiet_R6: assert (iorqN || m1N || (&ioSelN))
      else $error("device select during interrupt acknowledge");
    assert_we_needs_ram_R11: assert (ramWeN || (!ramCeN && !wrN))
      else $error("write strobe outside a RAM write");
    assert_oe_needs_rd_R10: assert ((romOeN && ramOeN) || !rdN)
      else $error("output enable without read");
  end
endmodule

// File: tb/z80_bus_decoder_bench.sv
module z80_bus_decoder_bench;
  typedef struct packed {
    logic       romCeN;
    logic       ramCeN;
    logic       romOeN;
    logic       ramOeN;
    logic       ramWeN;
    logic [2:0] romHi;
    logic [2:0] ramHi;
    logic [7:0] ioSel;
    logic [4:0] ioOff;
  } expect_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] addr = 16'h0000;
  logic mreqN = 1'b1, iorqN = 1'b1, rdN = 1'b1, wrN = 1'b1, m1N = 1'b1;
  logic [2:0] romBank = 3'd0;
  logic romCeN, ramCeN, romOeN, ramOeN, ramWeN;
  logic [2:0] romHiAddr, ramHiAddr;
  logic [7:0] ioSelN;
  logic [4:0] ioOffset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  expect_t q[$];

  z80_bus_decoder u_z80_bus_decoder (
    .addr(addr), .mreqN(mreqN), .iorqN(iorqN), .rdN(rdN), .wrN(wrN),
    .m1N(m1N), .romBank(romBank), .romCeN(romCeN), .ramCeN(ramCeN),
    .romOeN(romOeN), .ramOeN(ramOeN), .ramWeN(ramWeN),
    .romHiAddr(romHiAddr), .ramHiAddr(ramHiAddr),
    .ioSelN(ioSelN), .ioOffset(ioOffset)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (addr %h)", req, what, act, exp, addr);
    end
  endtask

  // driver: apply one bus state and queue the expected outputs
  task automatic drive(input logic [15:0] a, input logic mq, input logic iq,
                       input logic rd, input logic wr, input logic m1,
                       input logic [2:0] bank);
    expect_t e;
    bit romSel, ramSel;
    @(posedge clk);
    #1;
    addr = a; mreqN = mq; iorqN = iq; rdN = rd; wrN = wr; m1N = m1; romBank = bank;
    romSel = !mq && (a < 16'h2000);
    ramSel = !mq && (a >= 16'h2000);
    e.romCeN = !romSel;
    e.ramCeN = !ramSel;
    e.romOeN = !(romSel && !rd);
    e.ramOeN = !(ramSel && !rd);
    e.ramWeN = !(ramSel && !wr);
    e.romHi  = bank;
    e.ramHi  = 3'd0;
    e.ioSel  = 8'hFF;
    if (!iq && m1) e.ioSel[a[7:5]] = 1'b0;
    e.ioOff  = a[4:0];
    q.push_back(e);
  endtask

  // monitor: compare on the falling edge, away from the driving edge
  always @(negedge clk) begin
    if (rstN && q.size() > 0) begin
      expect_t e;
      e = q.pop_front();
      cmp(mreqN ? "R3" : "R1", "romCeN", int'(romCeN), int'(e.romCeN));
      cmp(mreqN ? "R3" : "R2", "ramCeN", int'(ramCeN), int'(e.ramCeN));
      cmp("R10", "romOeN", int'(romOeN), int'(e.romOeN));
      cmp("R10", "ramOeN", int'(ramOeN), int'(e.ramOeN));
      cmp("R11", "ramWeN", int'(ramWeN), int'(e.ramWeN));
      cmp("R8", "romHiAddr", int'(romHiAddr), int'(e.romHi));
      cmp("R9", "ramHiAddr", int'(ramHiAddr), int'(e.ramHi));
      cmp(iorqN ? "R5" : (m1N ? "R4" : "R6"), "ioSelN", int'(ioSelN), int'(e.ioSel));
      cmp("R7", "ioOffset", int'(ioOffset), int'(e.ioOff));
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset/idle state: nothing selected (R3, R5)
    drive(16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3'd0);
    // R4, R7: sweep every port with a live I/O read, random upper byte
    for (int p = 0; p < 256; p++)
      drive({8'($urandom), 8'(p)}, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0);
    // R4: I/O writes to each window's first and last port
    for (int d = 0; d < 8; d++) begin
      drive({8'h00, 3'(d), 5'h00}, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1);
      drive({8'h00, 3'(d), 5'h1F}, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1);
    end
    // R5: port sweep with I/O request idle
    for (int p = 0; p < 256; p++)
      drive({8'h00, 8'(p)}, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3'd2);
    // R6: interrupt acknowledge on several ports
    for (int p = 0; p < 256; p += 37)
      drive({8'h12, 8'(p)}, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'd3);
    // R1, R2, R8, R10, R11: boundary per bank, read and write
    for (int b = 0; b < 8; b++) begin
      drive(16'h1FFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'(b));
      drive(16'h2000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'(b));
      drive(16'h1FFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'(b));
      drive(16'h2000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'(b));
      drive(16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'(b));
      drive(16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'(b));
    end
    // R3, R9: memory request idle over both regions
    drive(16'h1000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3'd5);
    drive(16'h8000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd6);
    // mixed random bus states
    for (int k = 0; k < 300; k++)
      drive(16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 3'($urandom));
    repeat (3) @(posedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1 queue drain: actual %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule